// File: doc/BRIEF.md
# Four-Point Linear Convolution Unit

This block convolves two sequences of four unsigned 4-bit samples and returns the complete result of seven samples. All sixteen sample products are formed in parallel. Each product comes from a 4x4 multiplier built from vertical-and-crosswise 2x2 cells. The products are then added along the anti-diagonals of the product grid, so each output index collects the products whose two sample indices add up to it.

The surrounding logic presents both sequences on flat input vectors and pulses `start` for one clock. On that edge the result is computed from the inputs present and written into the output register. `done` is high for the next clock, and the result stays unchanged until the next start or reset.

Top module: `conv4_unit`

## Requirements
- R1: Output sample n equals the sum of x(k)*h(n-k) over all k for which both k and n-k lie in 0..3, for n = 0..6. Input sample i sits at bits [4i+3:4i] of its vector. Output sample n sits at bits [10n+9:10n] of `y_flat`.
- R2: Every sample product is the exact 8-bit unsigned product of its two 4-bit samples.
- R3: Each output sample is 10 bits wide and never wraps. With every input sample at 15 the result is [225 450 675 900 675 450 225].
- R4: With x = [1 2 3 4] and h = [5 6 7 8], the result is [5 16 34 60 61 52 32].
- R5: When `start` is high at a rising edge, `done` is high for the following clock. It is low in every cycle that does not follow a start.
- R6: While `start` is low, changes on `x_flat` and `h_flat` have no effect, and `y_flat` keeps its last value.
- R7: A synchronous active-low reset (`rst_n` low at a rising edge) clears `y_flat` and `done` to zero and overrides `start`.
- R8: Outputs 0 and 6 each use one product, outputs 1 and 5 use two, outputs 2 and 4 use three, and output 3 uses four. An impulse at x index j copies h into outputs j..j+3 and leaves every other output at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Capture pulse; inputs are sampled on this edge |
| x_flat | input | 16 | Four x samples, sample i at bits [4i+3:4i] |
| h_flat | input | 16 | Four h samples, sample i at bits [4i+3:4i] |
| y_flat | output | 70 | Seven result samples, sample n at bits [10n+9:10n] |
| done | output | 1 | High for one clock after a start |

## Verification
The document's worked sequences show the anti-diagonal summation is correct in a mixed case. Single-impulse x sequences at index 0 and at index 3 show whether each output draws on the right set of products and no others. A sweep of all 256 single-product pairs through output 0 separates multiplier faults from adder faults. Sequences at full scale and all zero test the width limits, and random sequences are compared with a software double loop. Further tests wiggle the inputs while idle and assert reset after a result, to check that the output holds and that reset clears it.

// File: rtl/conv_pkg.sv
// Shared sizing for the four-point convolution unit.
// Assumes unsigned samples; the multiplier cells are fixed at 4-bit operands.
package conv_pkg;
    localparam int SAMPLE_W = 4;
    localparam int PROD_W   = 2 * SAMPLE_W;
    localparam int TAPS     = 4;
    localparam int OUT_LEN  = 2 * TAPS - 1;
    localparam int OUT_W    = PROD_W + $clog2(TAPS);
    localparam int PROD_MAX = ((1 << SAMPLE_W) - 1) * ((1 << SAMPLE_W) - 1);
endpackage

// File: rtl/vc_mul2.sv
// 2x2 vertical-and-crosswise multiplier cell: four AND terms, two half adders.
// Assumes unsigned 2-bit operands; purely combinational.
module vc_mul2 (
    input  logic [1:0] a,
    input  logic [1:0] b,
    output logic [3:0] p
);
    logic cross_c;

    // Vertical column, crosswise column with carry, then top vertical with carry.
    always_comb begin
        p[0]    = a[0] & b[0];
        p[1]    = (a[1] & b[0]) ^ (a[0] & b[1]);
        cross_c = (a[1] & b[0]) & (a[0] & b[1]);
        p[2]    = (a[1] & b[1]) ^ cross_c;
        p[3]    = (a[1] & b[1]) & cross_c;
    end
endmodule

// File: rtl/vc_mul4.sv
// 4x4 vertical-and-crosswise multiplier built from four 2x2 cells.
// Assumes unsigned 4-bit operands; purely combinational, 8-bit exact product.
module vc_mul4 (
    input  logic [3:0] a,
    input  logic [3:0] b,
    output logic [7:0] p
);
    // Quarter products: index {a half, b half}, 0 = low half, 1 = high half.
    logic [3:0] quarter [4];

    for (genvar qa = 0; qa < 2; qa++) begin : g_ahalf
        for (genvar qb = 0; qb < 2; qb++) begin : g_bhalf
            vc_mul2 u_cell (
                .a (a[qa*2 +: 2]),
                .b (b[qb*2 +: 2]),
                .p (quarter[qa*2 + qb])
            );
        end
    end

    // Vertical halves concatenated, crosswise halves added at weight 4.
    always_comb begin
        p = {quarter[3], quarter[0]}
          + {2'b00, quarter[1], 2'b00}
          + {2'b00, quarter[2], 2'b00};
    end

    // a_r2_mul_exact: cell tree must match plain arithmetic product
    always_comb begin
        a_r2_mul_exact: assert (p == ({4'b0000, a} * {4'b0000, b}));
    end
endmodule

// File: rtl/conv_diag_sum.sv
// Adds the product grid along its anti-diagonals: output n takes grid(k, n-k).
// Assumes products are unsigned PROD_W bits; combinational.
module conv_diag_sum
    import conv_pkg::*;
(
    input  logic [TAPS*TAPS*PROD_W-1:0] grid,
    output logic [OUT_LEN*OUT_W-1:0]    sums
);
    for (genvar n = 0; n < OUT_LEN; n++) begin : g_lane
        logic [OUT_W-1:0] acc;

        // Accumulate every in-range pair whose indices add to n.
        always_comb begin
            acc = '0;
            for (int k = 0; k < TAPS; k++) begin
                if ((n - k) >= 0 && (n - k) < TAPS)
                    acc = acc + OUT_W'(grid[(k*TAPS + (n - k))*PROD_W +: PROD_W]);
            end
        end
        assign sums[n*OUT_W +: OUT_W] = acc;
    end
endmodule

// File: rtl/conv4_unit.sv
// Four-point linear convolution: sixteen parallel 4x4 products, anti-diagonal sums,
// registered result and one-cycle done flag. Inputs are used only on a start edge.
module conv4_unit
    import conv_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [TAPS*SAMPLE_W-1:0] x_flat,
    input  logic [TAPS*SAMPLE_W-1:0] h_flat,
    output logic [OUT_LEN*OUT_W-1:0] y_flat,
    output logic                     done
);
    logic [TAPS*TAPS*PROD_W-1:0] grid;
    logic [OUT_LEN*OUT_W-1:0]    lane_sum;

    for (genvar i = 0; i < TAPS; i++) begin : g_x
        for (genvar j = 0; j < TAPS; j++) begin : g_h
            vc_mul4 u_mul (
                .a (x_flat[i*SAMPLE_W +: SAMPLE_W]),
                .b (h_flat[j*SAMPLE_W +: SAMPLE_W]),
                .p (grid[(i*TAPS + j)*PROD_W +: PROD_W])
            );
        end
    end

    conv_diag_sum u_diag (
        .grid (grid),
        .sums (lane_sum)
    );

    // Result register: cleared by reset, loaded on start, otherwise held.
    always_ff @(posedge clk) begin
        if (!rst_n)
            y_flat <= '0;
        else if (start)
            y_flat <= lane_sum;
    end

    // Done flag: one clock after each accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n)
            done <= 1'b0;
        else
            done <= start;
    end

    a_r5_done_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);
    a_r5_done_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && $past(rst_n)) |=> !done);
    a_r6_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(y_flat));
    a_r7_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (done == 1'b0 && y_flat == '0));

    for (genvar n = 0; n < OUT_LEN; n++) begin : g_bound
        localparam int TERMS = (n < TAPS) ? (n + 1) : (OUT_LEN - n);
        a_r8_lane_bound: assert property (@(posedge clk) disable iff (!rst_n)
            y_flat[n*OUT_W +: OUT_W] <= OUT_W'(TERMS * PROD_MAX));
    end
endmodule

// File: tb/test_conv4_unit.sv
// Directed bench for conv4_unit: one task per scenario, each checks its own results.
module test_conv4_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [15:0] x_flat;
    logic [15:0] h_flat;
    logic [69:0] y_flat;
    logic        done;
    int          n_cmp = 0;
    int          n_bad = 0;

    conv4_unit i_conv4_unit (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .x_flat (x_flat),
        .h_flat (h_flat),
        .y_flat (y_flat),
        .done   (done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Software double loop over the sample pairs.
    function automatic logic [69:0] ref_conv(input logic [15:0] xv, input logic [15:0] hv);
        logic [69:0] r;
        int          s;
        r = '0;
        for (int n = 0; n < 7; n++) begin
            s = 0;
            for (int k = 0; k < 4; k++)
                if (n - k >= 0 && n - k < 4)
                    s += int'(xv[k*4 +: 4]) * int'(hv[(n-k)*4 +: 4]);
            r[n*10 +: 10] = 10'(s);
        end
        return r;
    endfunction

    function automatic logic [15:0] pack4(input int s0, input int s1, input int s2, input int s3);
        return {4'(s3), 4'(s2), 4'(s1), 4'(s0)};
    endfunction

    task automatic check(input string req, input string what, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req, input logic [69:0] exp);
        for (int n = 0; n < 7; n++)
            check(req, $sformatf("y%0d", n), longint'(y_flat[n*10 +: 10]), longint'(exp[n*10 +: 10]));
    endtask

    // Apply one start with the given sequences; returns at the negedge after the edge.
    task automatic run(input logic [15:0] xv, input logic [15:0] hv);
        @(negedge clk);
        x_flat = xv;
        h_flat = hv;
        start  = 1'b1;
        @(negedge clk);
        start  = 1'b0;
    endtask

    task automatic t_reset;
        rst_n  = 1'b0;
        start  = 1'b1;
        x_flat = 16'hFFFF;
        h_flat = 16'hFFFF;
        repeat (3) @(negedge clk);
        check("R7", "done in reset", longint'(done), 0);
        check("R7", "y in reset", longint'(y_flat != '0), 0);
        start = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_example;
        logic [69:0] exp;
        exp = {10'd32, 10'd52, 10'd61, 10'd60, 10'd34, 10'd16, 10'd5};
        run(pack4(1, 2, 3, 4), pack4(5, 6, 7, 8));
        check_all("R4", exp);
    endtask

    task automatic t_done_pulse;
        run(pack4(2, 0, 1, 0), pack4(3, 3, 0, 1));
        check("R5", "done after start", longint'(done), 1);
        @(negedge clk);
        check("R5", "done second cycle", longint'(done), 0);
    endtask

    task automatic t_impulse;
        logic [15:0] hv;
        hv = pack4(9, 4, 13, 7);
        run(pack4(1, 0, 0, 0), hv);
        check_all("R8", {30'd0, 10'd7, 10'd13, 10'd4, 10'd9});
        run(pack4(0, 0, 0, 1), hv);
        check_all("R8", {10'd7, 10'd13, 10'd4, 10'd9, 30'd0});
    endtask

    task automatic t_products;
        int bad_before;
        bad_before = n_bad;
        for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++) begin
                run(pack4(a, 0, 0, 0), pack4(b, 0, 0, 0));
                check("R2", $sformatf("y0 %0d*%0d", a, b), longint'(y_flat[9:0]), longint'(a * b));
            end
        if (n_bad != bad_before) $display("R2 product sweep had mismatches");
    endtask

    task automatic t_full_scale;
        run(16'hFFFF, 16'hFFFF);
        check_all("R3", {10'd225, 10'd450, 10'd675, 10'd900, 10'd675, 10'd450, 10'd225});
        run(16'h0000, 16'h0000);
        check_all("R1", '0);
    endtask

    task automatic t_random;
        logic [15:0] xv;
        logic [15:0] hv;
        for (int t = 0; t < 40; t++) begin
            xv = 16'($urandom);
            hv = 16'($urandom);
            run(xv, hv);
            check_all("R1", ref_conv(xv, hv));
        end
    endtask

    task automatic t_hold;
        logic [69:0] exp;
        exp = ref_conv(pack4(3, 1, 4, 1), pack4(5, 9, 2, 6));
        run(pack4(3, 1, 4, 1), pack4(5, 9, 2, 6));
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            x_flat = 16'($urandom);
            h_flat = 16'($urandom);
        end
        @(negedge clk);
        check_all("R6", exp);
        check("R6", "done idle", longint'(done), 0);
    endtask

    task automatic t_reset_mid;
        run(16'hFFFF, 16'h7777);
        @(negedge clk);
        rst_n = 1'b0;
        start = 1'b1;
        @(negedge clk);
        check("R7", "y after reset", longint'(y_flat != '0), 0);
        check("R7", "done with start in reset", longint'(done), 0);
        rst_n = 1'b1;
        start = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_example();
        t_done_pulse();
        t_impulse();
        t_products();
        t_full_scale();
        t_random();
        t_hold();
        t_reset_mid();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule